// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This unit is the execute stage of a 32-bit RISC datapath, limited to data-processing operations. Each cycle it takes a 4-bit operation code, a 4-bit condition code, a flag-set request, a first operand and a second operand. The second operand has already been through the barrel shifter, and the shifter's carry-out comes in with it. The unit tests the condition code against its stored N, Z, C and V flags. It produces the operation's result in the same cycle, together with a destination write enable. It updates the stored flags at the next clock edge.

There is no handshake. Every clock cycle holds one instruction. An idle cycle is issued with the never-execute condition. The result and the write enable are combinational from the inputs and the stored flags. The flag register is the only state. The flag register can be in one of two conditions from cycle to cycle: HOLD, where the flags keep their value, and UPDATE, where the computed flags are loaded. The transition to UPDATE is taken when the condition passes and either the operation is a compare or the flag-set request is high. In every other case the register stays in HOLD.

Top module: `cdp_alu`

## Requirements
- R1: While `rst_n` is low, and at the first cycle after it rises, `flags` reads 4'b0000.
- R2: The condition codes 0..13 select EQ (Z), NE (!Z), CS (C), CC (!C), MI (N), PL (!N), VS (V), VC (!V), HI (C&!Z), LS (!C|Z), GE (N==V), LT (N!=V), GT (!Z&N==V) and LE (Z|N!=V). Code 14 always passes, and code 15 never passes.
- R3: When the condition fails, `wr_en` is 0 and `flags` is unchanged after the clock edge.
- R4: The arithmetic operation codes are SUB=2 (a-b), RSB=3 (b-a), ADD=4 (a+b), ADC=5 (a+b+C), SBC=6 (a-b+C-1) and RSC=7 (b-a+C-1). Each result is taken modulo 2^32.
- R5: The logical and move operation codes are AND=0, EOR=1, ORR=12, MOV=13 (b), BIC=14 (a&~b) and MVN=15 (~b). MOV and MVN ignore `op_a`.
- R6: The compare codes are TST=8 (a&b), TEQ=9 (a^b), CMP=10 (a-b) and CMN=11 (a+b). When their condition passes they never assert `wr_en`, and they always update the flags, whatever `set_flags` holds.
- R7: A non-compare operation whose condition passes asserts `wr_en`. It updates the flags only when `set_flags` is 1.
- R8: Arithmetic operations and CMP/CMN set C to the adder carry-out, where C=1 means no borrow on a subtraction. They set V to signed overflow.
- R9: Logical, move, TST and TEQ operations set C from `shift_c` and leave V unchanged. For every operation, N is bit 31 of the result and Z is 1 when the result is zero.
- R10: `flags` is ordered {N,Z,C,V} from bit 3 down to bit 0. An update becomes visible in the cycle after the clock edge.
- R11: ADC, SBC and RSC use the stored C flag, not `shift_c`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| cond | input | 4 | Condition code |
| set_flags | input | 1 | Flag-update request for non-compare operations |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted |
| shift_c | input | 1 | Carry-out of the shifter |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write enable |
| flags | output | 4 | Stored {N,Z,C,V} |

## Verification
The assertions assume that `op`, `cond` and `set_flags` carry known values on every rising edge while out of reset. They also assume that every cycle is an instruction, so an idle cycle must carry the never-execute condition. The stimulus respects both assumptions. It holds code 15 on `cond` during reset and between bursts. It changes the inputs only on falling edges, so every rising edge sees one stable instruction. The stimulus covers condition outcomes with random flag states, which arise from long random runs of flag-setting operations. Directed cases cover carry, borrow, overflow and the zero result.

// File: rtl/cdp_alu_pkg.sv
package cdp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ, CC_NE, CC_CS, CC_CC, CC_MI, CC_PL, CC_VS, CC_VC,
        CC_HI, CC_LS, CC_GE, CC_LT, CC_GT, CC_LE, CC_AL, CC_NV
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic {
        FL_HOLD,
        FL_UPDATE
    } flag_act_e;

endpackage

// File: rtl/cdp_cond_check.sv
module cdp_cond_check
    import cdp_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] cond,
    input  nzcv_t      fl,
    output logic       pass
);

    always_comb begin
        unique case (cond_e'(cond))
            CC_EQ: pass = fl.z;
            CC_NE: pass = !fl.z;
            CC_CS: pass = fl.c;
            CC_CC: pass = !fl.c;
            CC_MI: pass = fl.n;
            CC_PL: pass = !fl.n;
            CC_VS: pass = fl.v;
            CC_VC: pass = !fl.v;
            CC_HI: pass = fl.c && !fl.z;
            CC_LS: pass = !fl.c || fl.z;
            CC_GE: pass = (fl.n == fl.v);
            CC_LT: pass = (fl.n != fl.v);
            CC_GT: pass = !fl.z && (fl.n == fl.v);
            CC_LE: pass = fl.z || (fl.n != fl.v);
            CC_AL: pass = 1'b1;
            CC_NV: pass = 1'b0;
        endcase
    end

    // R2: always-execute code never blocks
    p_always_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'd14) |-> pass);

    // R2: reserved code never executes
    p_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'd15) |-> !pass);

endmodule

// File: rtl/cdp_alu_core.sv
module cdp_alu_core
    import cdp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  nzcv_t          cur,
    input  logic           sh_c,
    output logic [W-1:0]   res,
    output nzcv_t          nxt,
    output logic           is_cmp
);

    localparam int MSB = W - 1;

    logic [W-1:0] x, y;
    logic         cin;
    logic         arith;
    logic [W:0]   sum;

    // Operand steering into one shared adder
    always_comb begin
        x     = a;
        y     = b;
        cin   = 1'b0;
        arith = 1'b1;
        unique case (op)
            OP_ADD, OP_CMN: ;
            OP_ADC:         cin = cur.c;
            OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1;  end
            OP_SBC:         begin y = ~b; cin = cur.c; end
            OP_RSB:         begin x = b; y = ~a; cin = 1'b1;  end
            OP_RSC:         begin x = b; y = ~a; cin = cur.c; end
            default:        arith = 1'b0;
        endcase
    end

    assign sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = sum[W-1:0];
        endcase
    end

    assign is_cmp = (op == OP_TST) || (op == OP_TEQ) ||
                    (op == OP_CMP) || (op == OP_CMN);

    always_comb begin
        nxt.n = res[MSB];
        nxt.z = (res == '0);
        nxt.c = arith ? sum[W] : sh_c;
        nxt.v = arith ? ((x[MSB] == y[MSB]) && (sum[MSB] != x[MSB])) : cur.v;
    end

endmodule

// File: rtl/cdp_flag_reg.sv
module cdp_flag_reg
    import cdp_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pass,
    input  logic  is_cmp,
    input  logic  set_flags,
    input  nzcv_t d,
    output nzcv_t q
);

    flag_act_e act;

    // Decide the action for this cycle
    always_comb begin
        if (pass && (is_cmp || set_flags)) act = FL_UPDATE;
        else                               act = FL_HOLD;
    end

    // Flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (act)
                FL_UPDATE: q <= d;
                FL_HOLD:   q <= q;
            endcase
        end
    end

    // R3: a failed condition leaves flags untouched
    p_fail_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pass |=> $stable(q));

    // R7: non-compare without flag request leaves flags untouched
    p_nos_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_cmp && !set_flags) |=> $stable(q));

endmodule

// File: rtl/cdp_alu.sv
module cdp_alu
    import cdp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op,
    input  logic [3:0]   cond,
    input  logic         set_flags,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         shift_c,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic [3:0]   flags
);

    nzcv_t fl_q;
    nzcv_t fl_d;
    logic  pass;
    logic  is_cmp;

    cdp_cond_check u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond),
        .fl    (fl_q),
        .pass  (pass)
    );

    cdp_alu_core #(.W(W)) u_core (
        .op     (alu_op_e'(op)),
        .a      (op_a),
        .b      (op_b),
        .cur    (fl_q),
        .sh_c   (shift_c),
        .res    (result),
        .nxt    (fl_d),
        .is_cmp (is_cmp)
    );

    cdp_flag_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass      (pass),
        .is_cmp    (is_cmp),
        .set_flags (set_flags),
        .d         (fl_d),
        .q         (fl_q)
    );

    assign wr_en = pass && !is_cmp;
    assign flags = fl_q;

    // R6: compare-class opcodes never write the destination
    p_cmp_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op[3:2] == 2'b10) |-> !wr_en);

    // R9: logical ops with flag update preserve V
    p_logic_v_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && set_flags && (op inside {4'd0, 4'd1, 4'd12, 4'd13, 4'd14, 4'd15}))
        |=> (flags[0] == $past(flags[0])));

    // R9: Z reflects a zero result after an update
    p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && (set_flags || op[3:2] == 2'b10))
        |=> (flags[2] == ($past(result) == '0)));

endmodule

// File: tb/tb_cdp_alu.sv
module tb_cdp_alu;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd13;
    logic [3:0]  cond = 4'd15;
    logic        set_flags = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        shift_c = 1'b0;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags;

    always #(CLK_P/2) clk = ~clk;

    cdp_alu dut (
        .clk(clk), .rst_n(rst_n), .op(op), .cond(cond), .set_flags(set_flags),
        .op_a(op_a), .op_b(op_b), .shift_c(shift_c),
        .result(result), .wr_en(wr_en), .flags(flags)
    );

    typedef struct {
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;
        string       tag;
    } item_t;

    item_t      sb[$];
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    logic [3:0] mfl = 4'b0000;   // model flags {N,Z,C,V}

    function automatic bit cond_ok(logic [3:0] c, logic [3:0] f);
        bit r;
        case (c[3:1])
            3'd0: r = f[2];
            3'd1: r = f[1];
            3'd2: r = f[3];
            3'd3: r = f[0];
            3'd4: r = f[1] && !f[2];
            3'd5: r = (f[3] == f[0]);
            3'd6: r = !f[2] && (f[3] == f[0]);
            default: return (c[0] == 1'b0);
        endcase
        return c[0] ? !r : r;
    endfunction

    task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic shc, input logic [3:0] f,
                         output logic [31:0] r, output logic [3:0] nf);
        longint ua, ub, sa, sb, full, sf, ci;
        bit     ar, cy, ov;
        ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ci = longint'(f[1]);
        ar = 1'b1; full = 0; sf = 0; cy = 1'b0; r = '0;
        case (o)
            4'd4, 4'd11: begin full = ua + ub;      sf = sa + sb;      cy = full >= (64'd1 << 32); end
            4'd5:        begin full = ua + ub + ci; sf = sa + sb + ci; cy = full >= (64'd1 << 32); end
            4'd2, 4'd10: begin full = ua - ub;      sf = sa - sb;      cy = full >= 0; end
            4'd6:        begin full = ua - ub + ci - 1; sf = sa - sb + ci - 1; cy = full >= 0; end
            4'd3:        begin full = ub - ua;      sf = sb - sa;      cy = full >= 0; end
            4'd7:        begin full = ub - ua + ci - 1; sf = sb - sa + ci - 1; cy = full >= 0; end
            default:     ar = 1'b0;
        endcase
        if (ar) begin
            r  = full[31:0];
            ov = (sf > 64'sd2147483647) || (sf < -64'sd2147483648);
            nf = {r[31], r == 32'd0, cy, ov};
        end else begin
            case (o)
                4'd0, 4'd8: r = a & b;
                4'd1, 4'd9: r = a ^ b;
                4'd12:      r = a | b;
                4'd13:      r = b;
                4'd14:      r = a & ~b;
                default:    r = ~b;
            endcase
            nf = {r[31], r == 32'd0, shc, f[0]};
        end
    endtask

    // Driver: one instruction per cycle, expected item into the scoreboard
    task automatic issue(input logic [3:0] o, input logic [3:0] c, input logic s,
                         input logic [31:0] a, input logic [31:0] b, input logic shc,
                         input string tag);
        item_t       it;
        logic [31:0] r;
        logic [3:0]  nf;
        bit          p, cmpk;
        @(negedge clk);
        op = o; cond = c; set_flags = s; op_a = a; op_b = b; shift_c = shc;
        model(o, a, b, shc, mfl, r, nf);
        p    = cond_ok(c, mfl);
        cmpk = (o >= 4'd8) && (o <= 4'd11);
        it.res = r;
        it.we  = p && !cmpk;
        if (p && (cmpk || s)) mfl = nf;
        it.fl  = mfl;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        cond = 4'd15; set_flags = 1'b0;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // Monitor: compare combinational outputs before the edge, flags after
    initial begin
        item_t       it;
        logic [31:0] r_s;
        logic        we_s;
        forever begin
            @(negedge clk);
            #(CLK_P/2 - 1);
            if (sb.size() > 0) begin
                it   = sb.pop_front();
                r_s  = result;
                we_s = wr_en;
                @(posedge clk);
                #1;
                check(we_s == it.we, it.tag, "wr_en", {31'b0, we_s}, {31'b0, it.we});
                check(flags == it.fl, it.tag, "flags", {28'b0, flags}, {28'b0, it.fl});
                if (it.we)
                    check(r_s == it.res, it.tag, "result", r_s, it.res);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(flags == 4'b0000, "R1", "flags in reset", {28'b0, flags}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(flags == 4'b0000, "R1", "flags after reset", {28'b0, flags}, 32'h0);

        // R4/R8: carry-out and zero on ADD with flags
        issue(4'd4, 4'd14, 1'b1, 32'hFFFF_FFFF, 32'h1, 1'b0, "R8");
        // R10: EQ now passes since Z was set by the previous edge
        issue(4'd13, 4'd0, 1'b0, 32'h0, 32'h1234_5678, 1'b0, "R10");
        // R8: signed overflow on ADD
        issue(4'd4, 4'd14, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0, "R8");
        // R7: SUB without flag request leaves flags
        issue(4'd2, 4'd14, 1'b0, 32'd5, 32'd9, 1'b0, "R7");
        // R8: SUB equal operands, no borrow
        issue(4'd2, 4'd14, 1'b1, 32'd5, 32'd5, 1'b0, "R8");
        // R11: ADC uses stored C=1 while shift_c=0
        issue(4'd5, 4'd14, 1'b0, 32'd10, 32'd20, 1'b0, "R11");
        // R11: SBC and RSC with stored C
        issue(4'd6, 4'd14, 1'b1, 32'd10, 32'd20, 1'b1, "R11");
        issue(4'd7, 4'd14, 1'b0, 32'd10, 32'd20, 1'b1, "R11");
        // R4: RSB swaps operands
        issue(4'd3, 4'd14, 1'b1, 32'd3, 32'd100, 1'b0, "R4");
        // R6: CMP with S low still updates flags, no write
        issue(4'd10, 4'd14, 1'b0, 32'd1, 32'd2, 1'b0, "R6");
        // R9: TST takes C from shifter, V kept
        issue(4'd8, 4'd14, 1'b0, 32'hF0, 32'h0F, 1'b1, "R9");
        // R5: MOV/MVN ignore op_a, BIC clears bits
        issue(4'd13, 4'd14, 1'b0, 32'hDEAD_BEEF, 32'h55, 1'b0, "R5");
        issue(4'd15, 4'd14, 1'b1, 32'hDEAD_BEEF, 32'h0, 1'b0, "R5");
        issue(4'd14, 4'd14, 1'b0, 32'hFF, 32'h0F, 1'b0, "R5");
        // R3: failing condition blocks write and flags (NV)
        issue(4'd10, 4'd15, 1'b1, 32'd0, 32'd0, 1'b1, "R3");
        // R2: sweep every condition code after a CMP
        for (int k = 0; k < 16; k++) begin
            issue(4'd10, 4'd14, 1'b0, 32'($urandom_range(0, 3)), 32'($urandom_range(0, 3)), 1'b0, "R6");
            issue(4'd13, 4'(k), 1'b0, 32'd0, 32'(k + 1), 1'b0, "R2");
        end
        // Random mix of everything
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  o;
            logic [3:0]  c;
            logic [31:0] a, b;
            string       t;
            o = 4'($urandom);
            c = 4'($urandom);
            a = ($urandom_range(0, 3) == 0) ? 32'h8000_0000 - 32'($urandom_range(0, 2)) : $urandom;
            b = ($urandom_range(0, 3) == 0) ? a : $urandom;
            if (!cond_ok(c, mfl))             t = "R3";
            else if (o >= 4'd8 && o <= 4'd11) t = "R6";
            else if (o >= 4'd2 && o <= 4'd7)  t = "R4";
            else                              t = "R5";
            issue(o, c, 1'($urandom), a, b, 1'($urandom), t);
        end
        idle();
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R10", "scoreboard drained", 32'(sb.size()), 32'h0);
        finish_run();
    end

endmodule